// File: doc/BRIEF.md
# Relative Branch and Call Sequencer

This block works out where a small 8-bit controller goes next after a control-transfer instruction. The fetch stage hands it the opcode and two operand bytes, together with the instruction's own address, the carry flag, the accumulator, the value of a tested bit and the stack pointer. The block evaluates the branch condition and reports the next program counter with a taken flag. For a long call it also issues the two stack writes that save the return address, and it reports the updated stack pointer.

Four short conditional branches are handled: bit clear, carry clear, accumulator zero and accumulator non-zero. Two absolute transfers are handled as well: the long jump and the long call. A relative branch first moves past the full instruction. If its condition holds, the signed displacement is then added to that advanced address. Every accepted instruction completes in two clock cycles. The result is valid in the cycle where `done` is high. The caller's stack RAM takes one write per strobe.

Top module: `rel_branch_seq`

## Requirements
- R1: A request on `instr_valid` is accepted only while `busy` is low. `busy` is high for the next two cycles and `done` is high in the second of them only. Requests and input changes while busy have no effect on the result.
- R2: Opcode 0x30 (bit-clear branch, 3 bytes) is taken iff `bit_val` is 0. `pc_next` is pc+3, plus the displacement from the third byte when taken.
- R3: Opcode 0x50 (carry-clear branch, 2 bytes) is taken iff `carry` is 0. `pc_next` is pc+2, plus the displacement from the second byte when taken.
- R4: Opcode 0x60 (accumulator-zero branch, 2 bytes) is taken only when all eight accumulator bits are 0. It uses the second-byte displacement.
- R5: Opcode 0x70 (accumulator-non-zero branch, 2 bytes) is taken when any accumulator bit is 1. It uses the second-byte displacement.
- R6: The displacement is an 8-bit two's complement value, sign-extended to 16 bits. All PC arithmetic wraps modulo 65536.
- R7: Opcode 0x02 (long jump, 3 bytes) gives `pc_next` = {second byte, third byte} with `taken` high.
- R8: Opcode 0x12 (long call) writes the low byte of pc+3 to address sp+1 in the first busy cycle. It writes the high byte to sp+2 in the second. Each write is a one-cycle `stk_we` strobe, and the address wraps modulo 256.
- R9: At completion of a long call, `pc_next` = {second byte, third byte}, `taken` is high and `sp_out` = sp+2 (mod 256).
- R10: For every opcode other than the long call, `stk_we` stays low and `sp_out` equals the accepted stack pointer.
- R11: Any other opcode completes with `taken` low and `pc_next` equal to the accepted PC.
- R12: After reset, `busy`, `done`, `taken` and `stk_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Request to execute the presented instruction |
| opcode | input | 8 | First instruction byte |
| op_b1 | input | 8 | Second instruction byte |
| op_b2 | input | 8 | Third instruction byte (unused by 2-byte forms) |
| pc_in | input | 16 | Address of the instruction's first byte |
| carry | input | 1 | Carry flag |
| acc | input | 8 | Accumulator value |
| bit_val | input | 1 | Value of the addressed bit |
| sp_in | input | 8 | Stack pointer before the instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Result valid this cycle |
| pc_next | output | 16 | Next program counter (valid with done) |
| taken | output | 1 | Transfer taken (valid with done) |
| sp_out | output | 8 | Stack pointer after the instruction (valid with done) |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 8 | Stack write address |
| stk_wdata | output | 8 | Stack write data |

## Verification
Each conditional branch is tried with its condition true and false. The zero and non-zero forms see the accumulator at 0x00, 0x01 and 0x80, so a test of only the low or only the top bit would show up. Forward, backward and most-negative displacements, and a PC at the top of the space, separate a correct 8-to-16 sign extension and modulo wrap from zero extension or a wrong base address. Calls from the worked example and with the stack pointer at 0xFF check byte order, pre-increment and address wrap. A request held high while busy confirms that the latched instruction is not disturbed.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  parameter int unsigned PC_W   = 16;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned SP_W   = 8;

  localparam int unsigned RET_BYTES = PC_W / DATA_W;
  localparam int unsigned PH_W      = (RET_BYTES > 1) ? $clog2(RET_BYTES) : 1;

  localparam logic [DATA_W-1:0] OPC_JBIT_CLR = 8'h30;
  localparam logic [DATA_W-1:0] OPC_JCY_CLR  = 8'h50;
  localparam logic [DATA_W-1:0] OPC_JACC_Z   = 8'h60;
  localparam logic [DATA_W-1:0] OPC_JACC_NZ  = 8'h70;
  localparam logic [DATA_W-1:0] OPC_FARJUMP  = 8'h02;
  localparam logic [DATA_W-1:0] OPC_FARCALL  = 8'h12;

  typedef enum logic [2:0] {
    K_NONE,
    K_BIT_CLR,
    K_CY_CLR,
    K_ACC_Z,
    K_ACC_NZ,
    K_FARJUMP,
    K_FARCALL
  } xfer_kind_e;

  // Sign-extend a relative displacement to PC width.
  function automatic logic [PC_W-1:0] sext_disp(input logic [DATA_W-1:0] d);
    return {{(PC_W-DATA_W){d[DATA_W-1]}}, d};
  endfunction

  // Advance a PC by an instruction length, modulo 2^PC_W.
  function automatic logic [PC_W-1:0] pc_step(input logic [PC_W-1:0] pc,
                                              input logic [1:0] len);
    return pc + PC_W'(len);
  endfunction

  // Advance a stack pointer, modulo 2^SP_W.
  function automatic logic [SP_W-1:0] sp_step(input logic [SP_W-1:0] sp,
                                              input int unsigned k);
    return sp + SP_W'(k);
  endfunction
endpackage

// File: rtl/rbs_decode.sv
module rbs_decode
  import rbs_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output xfer_kind_e        kind,
  output logic [1:0]        ilen,
  output logic              disp_late
);
  always_comb begin
    kind      = K_NONE;
    ilen      = 2'd0;
    disp_late = 1'b0;
    unique case (opcode)
      OPC_JBIT_CLR: begin kind = K_BIT_CLR; ilen = 2'd3; disp_late = 1'b1; end
      OPC_JCY_CLR:  begin kind = K_CY_CLR;  ilen = 2'd2; end
      OPC_JACC_Z:   begin kind = K_ACC_Z;   ilen = 2'd2; end
      OPC_JACC_NZ:  begin kind = K_ACC_NZ;  ilen = 2'd2; end
      OPC_FARJUMP:  begin kind = K_FARJUMP; ilen = 2'd3; end
      OPC_FARCALL:  begin kind = K_FARCALL; ilen = 2'd3; end
      default:      begin kind = K_NONE;    ilen = 2'd0; end
    endcase
  end
endmodule

// File: rtl/rbs_cond.sv
module rbs_cond
  import rbs_pkg::*;
(
  input  xfer_kind_e        kind,
  input  logic              carry,
  input  logic [DATA_W-1:0] acc,
  input  logic              bit_val,
  output logic              cond_hold
);
  logic acc_is_zero;
  assign acc_is_zero = ~|acc;

  always_comb begin
    unique case (kind)
      K_BIT_CLR: cond_hold = ~bit_val;
      K_CY_CLR:  cond_hold = ~carry;
      K_ACC_Z:   cond_hold = acc_is_zero;
      K_ACC_NZ:  cond_hold = ~acc_is_zero;
      K_FARJUMP,
      K_FARCALL: cond_hold = 1'b1;
      default:   cond_hold = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbs_target.sv
module rbs_target
  import rbs_pkg::*;
(
  input  xfer_kind_e        kind,
  input  logic [1:0]        ilen,
  input  logic              disp_late,
  input  logic [PC_W-1:0]   pc,
  input  logic [DATA_W-1:0] b1,
  input  logic [DATA_W-1:0] b2,
  input  logic              cond_hold,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   dest_pc
);
  logic [DATA_W-1:0] disp;
  logic [PC_W-1:0]   abs_pc;
  logic [PC_W-1:0]   rel_pc;

  assign seq_pc = pc_step(pc, ilen);
  assign disp   = disp_late ? b2 : b1;
  assign rel_pc = seq_pc + sext_disp(disp);
  assign abs_pc = PC_W'({b1, b2});

  always_comb begin
    unique case (kind)
      K_BIT_CLR, K_CY_CLR, K_ACC_Z, K_ACC_NZ: dest_pc = cond_hold ? rel_pc : seq_pc;
      K_FARJUMP, K_FARCALL:                   dest_pc = abs_pc;
      default:                                dest_pc = pc;
    endcase
  end
endmodule

// File: rtl/rbs_push.sv
module rbs_push
  import rbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [PH_W-1:0]   phase,
  input  logic [SP_W-1:0]   sp,
  input  logic [PC_W-1:0]   ret_pc,
  output logic              we,
  output logic [SP_W-1:0]   addr,
  output logic [DATA_W-1:0] wdata,
  output logic [SP_W-1:0]   sp_final
);
  logic [DATA_W-1:0] lane [RET_BYTES];

  // Byte lanes of the return address, least significant first.
  for (genvar g = 0; g < RET_BYTES; g++) begin : g_lane
    assign lane[g] = ret_pc[g*DATA_W +: DATA_W];
  end

  assign we       = active;
  assign addr     = sp + SP_W'(phase) + SP_W'(1);
  assign wdata    = lane[phase];
  assign sp_final = sp_step(sp, RET_BYTES);

  // R8: pushes go to consecutive addresses on consecutive cycles
  assert_push_consecutive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && phase == PH_W'(0)) |=> (we && addr == SP_W'($past(addr) + SP_W'(1))));
endmodule

// File: rtl/rel_branch_seq.sv
module rel_branch_seq
  import rbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [7:0]        opcode,
  input  logic [7:0]        op_b1,
  input  logic [7:0]        op_b2,
  input  logic [15:0]       pc_in,
  input  logic              carry,
  input  logic [7:0]        acc,
  input  logic              bit_val,
  input  logic [7:0]        sp_in,
  output logic              busy,
  output logic              done,
  output logic [15:0]       pc_next,
  output logic              taken,
  output logic [7:0]        sp_out,
  output logic              stk_we,
  output logic [7:0]        stk_addr,
  output logic [7:0]        stk_wdata
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(RET_BYTES - 1);

  logic [DATA_W-1:0] r_op, r_b1, r_b2, r_acc;
  logic [PC_W-1:0]   r_pc;
  logic [SP_W-1:0]   r_sp;
  logic              r_cy, r_bit;
  logic [PH_W-1:0]   phase;
  logic              accept;

  xfer_kind_e        kind;
  logic [1:0]        ilen;
  logic              disp_late;
  logic              cond_hold;
  logic [PC_W-1:0]   seq_pc, dest_pc;
  logic [SP_W-1:0]   sp_final;
  logic              is_call;

  assign accept = instr_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
      r_op  <= '0;
      r_b1  <= '0;
      r_b2  <= '0;
      r_acc <= '0;
      r_pc  <= '0;
      r_sp  <= '0;
      r_cy  <= 1'b0;
      r_bit <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
      r_op  <= opcode;
      r_b1  <= op_b1;
      r_b2  <= op_b2;
      r_acc <= acc;
      r_pc  <= pc_in;
      r_sp  <= sp_in;
      r_cy  <= carry;
      r_bit <= bit_val;
    end else if (busy) begin
      if (phase == LAST_PH) busy <= 1'b0;
      else                  phase <= phase + PH_W'(1);
    end
  end

  rbs_decode u_decode (
    .opcode    (r_op),
    .kind      (kind),
    .ilen      (ilen),
    .disp_late (disp_late)
  );

  rbs_cond u_cond (
    .kind      (kind),
    .carry     (r_cy),
    .acc       (r_acc),
    .bit_val   (r_bit),
    .cond_hold (cond_hold)
  );

  rbs_target u_target (
    .kind      (kind),
    .ilen      (ilen),
    .disp_late (disp_late),
    .pc        (r_pc),
    .b1        (r_b1),
    .b2        (r_b2),
    .cond_hold (cond_hold),
    .seq_pc    (seq_pc),
    .dest_pc   (dest_pc)
  );

  assign is_call = busy && (kind == K_FARCALL);

  rbs_push u_push (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (is_call),
    .phase    (phase),
    .sp       (r_sp),
    .ret_pc   (seq_pc),
    .we       (stk_we),
    .addr     (stk_addr),
    .wdata    (stk_wdata),
    .sp_final (sp_final)
  );

  assign done    = busy && (phase == LAST_PH);
  assign pc_next = dest_pc;
  assign taken   = done && cond_hold;
  assign sp_out  = (kind == K_FARCALL) ? sp_final : r_sp;

  // R1: the first busy cycle is always followed by completion
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> done);
  // R1: the block returns to idle right after completion
  assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R10: only a decoded long call drives the stack
  assert_we_call_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (busy && kind == K_FARCALL));
  // R9: the final stack pointer is the last written address
  assert_final_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stk_we) |-> (sp_out == stk_addr));
  // R12: nothing is reported while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!stk_we && !taken && !done));
endmodule

// File: tb/test_rel_branch_seq.sv
`timescale 1ns/1ps
module test_rel_branch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [7:0]  opcode = '0, op_b1 = '0, op_b2 = '0, acc = '0, sp_in = '0;
  logic [15:0] pc_in = '0;
  logic        carry = 1'b0, bit_val = 1'b0;
  logic        busy, done, taken, stk_we;
  logic [15:0] pc_next;
  logic [7:0]  sp_out, stk_addr, stk_wdata;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ram [256];

  // captured per phase
  logic       p1_busy, p1_done, p1_we, p2_done, p2_we, p2_taken, p3_busy;
  logic [7:0] p1_addr, p1_data, p2_addr, p2_data, p2_sp;
  logic [15:0] p2_pc;

  always #2.5 clk = ~clk;

  rel_branch_seq i_rel_branch_seq (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
    .op_b1(op_b1), .op_b2(op_b2), .pc_in(pc_in), .carry(carry), .acc(acc),
    .bit_val(bit_val), .sp_in(sp_in), .busy(busy), .done(done),
    .pc_next(pc_next), .taken(taken), .sp_out(sp_out), .stk_we(stk_we),
    .stk_addr(stk_addr), .stk_wdata(stk_wdata)
  );

  always @(posedge clk) if (stk_we) ram[stk_addr] <= stk_wdata;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rel_dest(input logic [15:0] pc, input int len,
                                           input logic [7:0] d, input logic tk);
    int t;
    t = int'(pc) + len;
    if (tk) t = t + ((int'(d) > 127) ? int'(d) - 256 : int'(d));
    return 16'(t);
  endfunction

  task automatic issue(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [15:0] pc, input logic cy, input logic [7:0] a,
                       input logic bt, input logic [7:0] sp, input logic hold_valid);
    @(negedge clk);
    opcode = op; op_b1 = b1; op_b2 = b2; pc_in = pc; carry = cy; acc = a;
    bit_val = bt; sp_in = sp; instr_valid = 1'b1;
    @(negedge clk);
    if (hold_valid) begin
      opcode = 8'h02; op_b1 = 8'hAA; op_b2 = 8'h55; pc_in = 16'h4444;
      sp_in = 8'h80; acc = ~a; carry = ~cy; bit_val = ~bt;
    end else instr_valid = 1'b0;
    p1_busy = busy; p1_done = done; p1_we = stk_we; p1_addr = stk_addr; p1_data = stk_wdata;
    @(negedge clk);
    instr_valid = 1'b0;
    p2_done = done; p2_we = stk_we; p2_addr = stk_addr; p2_data = stk_wdata;
    p2_pc = pc_next; p2_taken = taken; p2_sp = sp_out;
    @(negedge clk);
    p3_busy = busy;
  endtask

  task automatic check_timing(input string req);
    chk(req, "busy in cycle 1", 32'(p1_busy), 32'd1);
    chk(req, "done in cycle 1", 32'(p1_done), 32'd0);
    chk(req, "done in cycle 2", 32'(p2_done), 32'd1);
    chk(req, "busy after done", 32'(p3_busy), 32'd0);
  endtask

  task automatic check_nocall(input string req, input logic [7:0] sp);
    chk(req, "stk_we cycle 1", 32'(p1_we), 32'd0);
    chk(req, "stk_we cycle 2", 32'(p2_we), 32'd0);
    chk(req, "sp_out", 32'(p2_sp), 32'(sp));
  endtask

  task automatic do_branch(input string req, input logic [7:0] op, input int len,
                           input logic [7:0] d, input logic [15:0] pc, input logic cy,
                           input logic [7:0] a, input logic bt, input logic exp_tk);
    logic [7:0] b1, b2;
    b1 = (len == 3) ? 8'h21 : d;
    b2 = (len == 3) ? d : 8'hC3;
    issue(op, b1, b2, pc, cy, a, bt, 8'h3C, 1'b0);
    check_timing("R1");
    chk(req, "taken", 32'(p2_taken), 32'(exp_tk));
    chk(req, "pc_next", 32'(p2_pc), 32'(rel_dest(pc, len, d, exp_tk)));
    check_nocall("R10", 8'h3C);
  endtask

  task automatic test_reset();
    chk("R12", "busy", 32'(busy), 32'd0);
    chk("R12", "done", 32'(done), 32'd0);
    chk("R12", "taken", 32'(taken), 32'd0);
    chk("R12", "stk_we", 32'(stk_we), 32'd0);
  endtask

  task automatic test_bit_clear();
    do_branch("R2", 8'h30, 3, 8'h10, 16'h1000, 1'b1, 8'h00, 1'b0, 1'b1);
    do_branch("R2", 8'h30, 3, 8'h10, 16'h1000, 1'b0, 8'h00, 1'b1, 1'b0);
    do_branch("R6", 8'h30, 3, 8'hF0, 16'h1000, 1'b1, 8'hFF, 1'b0, 1'b1);
  endtask

  task automatic test_carry_clear();
    do_branch("R3", 8'h50, 2, 8'h7F, 16'h0200, 1'b0, 8'h00, 1'b1, 1'b1);
    do_branch("R3", 8'h50, 2, 8'h7F, 16'h0200, 1'b1, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic test_acc_zero();
    do_branch("R4", 8'h60, 2, 8'h80, 16'h0050, 1'b0, 8'h00, 1'b0, 1'b1); // wraps below 0
    do_branch("R4", 8'h60, 2, 8'h80, 16'h0050, 1'b0, 8'h01, 1'b0, 1'b0);
    do_branch("R4", 8'h60, 2, 8'h80, 16'h0050, 1'b0, 8'h80, 1'b0, 1'b0);
  endtask

  task automatic test_acc_nonzero();
    do_branch("R5", 8'h70, 2, 8'h05, 16'h3000, 1'b0, 8'h80, 1'b0, 1'b1);
    do_branch("R5", 8'h70, 2, 8'h05, 16'h3000, 1'b0, 8'h01, 1'b0, 1'b1);
    do_branch("R5", 8'h70, 2, 8'h05, 16'h3000, 1'b0, 8'h00, 1'b0, 1'b0);
    do_branch("R6", 8'h70, 2, 8'h05, 16'hFFFF, 1'b0, 8'h42, 1'b0, 1'b1); // wraps above top
  endtask

  task automatic test_long_jump();
    issue(8'h02, 8'h12, 8'h34, 16'h0123, 1'b1, 8'h00, 1'b1, 8'h55, 1'b0);
    check_timing("R1");
    chk("R7", "pc_next", 32'(p2_pc), 32'h1234);
    chk("R7", "taken", 32'(p2_taken), 32'd1);
    check_nocall("R10", 8'h55);
  endtask

  task automatic test_call(input logic [15:0] pc, input logic [7:0] sp, input logic hold);
    logic [15:0] ret;
    ret = pc + 16'd3;
    issue(8'h12, 8'h12, 8'h34, pc, 1'b0, 8'h00, 1'b0, sp, hold);
    check_timing("R1");
    chk("R8", "we cycle 1", 32'(p1_we), 32'd1);
    chk("R8", "addr cycle 1", 32'(p1_addr), 32'(8'(sp + 8'd1)));
    chk("R8", "data cycle 1", 32'(p1_data), 32'(ret[7:0]));
    chk("R8", "we cycle 2", 32'(p2_we), 32'd1);
    chk("R8", "addr cycle 2", 32'(p2_addr), 32'(8'(sp + 8'd2)));
    chk("R8", "data cycle 2", 32'(p2_data), 32'(ret[15:8]));
    chk("R8", "ram low", 32'(ram[8'(sp + 8'd1)]), 32'(ret[7:0]));
    chk("R8", "ram high", 32'(ram[8'(sp + 8'd2)]), 32'(ret[15:8]));
    chk("R9", "pc_next", 32'(p2_pc), 32'h1234);
    chk("R9", "taken", 32'(p2_taken), 32'd1);
    chk("R9", "sp_out", 32'(p2_sp), 32'(8'(sp + 8'd2)));
  endtask

  task automatic test_other();
    issue(8'h00, 8'h12, 8'h34, 16'h0777, 1'b0, 8'h00, 1'b0, 8'h21, 1'b0);
    check_timing("R1");
    chk("R11", "pc_next", 32'(p2_pc), 32'h0777);
    chk("R11", "taken", 32'(p2_taken), 32'd0);
    check_nocall("R10", 8'h21);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    #12 test_reset();
    rst_n = 1'b1;
    test_bit_clear();
    test_carry_clear();
    test_acc_zero();
    test_acc_nonzero();
    test_long_jump();
    test_call(16'h0123, 8'h07, 1'b0);
    test_call(16'hFFFE, 8'hFF, 1'b0);
    test_call(16'h0123, 8'h40, 1'b1); // R1: request held while busy is ignored
    test_other();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule